// File: doc/BRIEF.md
# Multiword DMA Strobe Timing Generator

This block drives the read and write strobes of one parallel ATA channel during multiword DMA bursts. Its clock runs at 16 MHz, so one clock period is 62.5 ns. Strobe widths are not freely programmable. Each device on the channel instead holds a two-bit profile code, and the code picks one of four fixed pairs: a strobe-low count and a strobe-high recovery count, in clock periods. The slowest pair is the reset default.

A transfer begins with a one-cycle `start` pulse that names the device, the direction and the number of 16-bit words. At that moment the block latches the device's profile and the direction. It then lowers `dmack_n` and waits for the drive's `dmarq`. Every word takes one strobe pulse followed by its recovery time, and each new pulse waits for `dmarq`. When the last recovery time ends, `done` pulses for a single clock and the channel goes idle again.

The channel is simplex. Only one transfer can be in flight, and while one is in flight the block ignores both a new `start` and any write to a device's profile register.

Top module: `mwdma_strobe_gen`

## Requirements
- R1: After reset both strobes and `dmack_n` are high, `busy` and `done` are low, and every device's profile is code 0.
- R2: Profile codes map to strobe-low / recovery-high lengths in clock periods as follows: code 0 gives 4/5, code 1 gives 3/4, code 2 gives 2/2 and code 3 gives 1/2. When `dmarq` stays high, consecutive words are spaced by exactly these lengths.
- R3: Direction 0 pulses only `dior_n`. Direction 1 pulses only `diow_n`. The unused strobe stays high for the whole transfer.
- R4: A strobe pulse begins only in a clock after one where `dmarq` was high. While `dmarq` is low before a word, both strobes stay high and `dmack_n` stays low.
- R5: A transfer produces exactly `start_words` strobe pulses. `done` is high for exactly one clock after the last recovery time, and then `busy` falls. A word count of 0 pulses `done` in the clock after the start, with no strobe at all.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The transfer in flight keeps its word count, device and direction.
- R7: A profile write (`cfg_we`) that arrives while `busy` is high is ignored. The register keeps its old code for later transfers.
- R8: The profile and direction are latched when a transfer is accepted. Changing `start_dir` or the device's register later does not change the transfer in flight.
- R9: Each device has its own profile register. A write to one device does not change the timing of another.
- R10: `dmack_n` is low whenever a strobe is low, and high again once `done` has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz timing clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for a device profile register |
| cfg_dev | input | DEV_W | Device whose profile is written |
| cfg_profile | input | 2 | Profile code to write (0 slowest, 3 fastest) |
| start | input | 1 | One-cycle request to begin a transfer |
| start_dev | input | DEV_W | Device addressed by the transfer |
| start_dir | input | 1 | 0 = read from drive, 1 = write to drive |
| start_words | input | CNT_W | Number of 16-bit words to move |
| dmarq | input | 1 | DMA request from the drive |
| dmack_n | output | 1 | DMA acknowledge to the drive, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A transfer is in flight |
| done | output | 1 | One-clock pulse at the end of a transfer |

## Verification
The bench measures the length of every strobe-low run and every inter-word high gap for each profile code and both directions. A decoder with a swapped or off-by-one count therefore shows up as a wrong run length, not just a slow transfer. It starts a transfer while `dmarq` is held low, which catches a design that pulses a strobe before the drive has asked for a word, and it starts one with a zero word count, which catches a design that still emits a stray pulse. In the middle of a transfer it fires a second `start`, a profile write to the active device and a flipped `start_dir`. A design that does not latch its settings at the start, or that accepts these inputs while busy, would then change the pulse count, the timing, the strobe used or the next transfer's timing.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

    localparam int TMR_W = 3;

    typedef enum logic [1:0] {
        PROF_A = 2'd0,
        PROF_B = 2'd1,
        PROF_C = 2'd2,
        PROF_D = 2'd3
    } profile_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACT,
        ST_REC,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [TMR_W-1:0] act;
        logic [TMR_W-1:0] rec;
    } phase_t;

    typedef struct packed {
        profile_e prof;
        logic     dir;
    } xfer_cfg_t;

    // Strobe-low and recovery lengths in 62.5 ns clock periods.
    function automatic phase_t profile_phases(profile_e p);
        phase_t ph;
        case (p)
            PROF_A:  begin ph.act = TMR_W'(4); ph.rec = TMR_W'(5); end
            PROF_B:  begin ph.act = TMR_W'(3); ph.rec = TMR_W'(4); end
            PROF_C:  begin ph.act = TMR_W'(2); ph.rec = TMR_W'(2); end
            default: begin ph.act = TMR_W'(1); ph.rec = TMR_W'(2); end
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/mwdma_mode_regs.sv
module mwdma_mode_regs
    import mwdma_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] wr_dev,
    input  profile_e         wr_prof,
    input  logic [DEV_W-1:0] rd_dev,
    output profile_e         rd_prof
);

    profile_e prof_q [NUM_DEV];

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst) begin
                prof_q[d] <= PROF_A;
            end else if (wr_en && (wr_dev == DEV_W'(d))) begin
                prof_q[d] <= wr_prof;
            end
        end
    end

    always_comb begin
        rd_prof = PROF_A;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (rd_dev == DEV_W'(d)) rd_prof = prof_q[d];
        end
    end

endmodule

// File: rtl/mwdma_word_counter.sv
module mwdma_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && (remaining != '0)) begin
            remaining <= remaining - CNT_W'(1);
        end
    end

    assign last = (remaining == '0);

endmodule

// File: rtl/mwdma_phase_ctrl.sv
module mwdma_phase_ctrl
    import mwdma_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch,
    input  logic   launch_empty,
    input  logic   dmarq,
    input  logic   last_word,
    input  phase_t phases,
    output state_e state,
    output logic   word_end
);

    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) state <= launch_empty ? ST_DONE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (dmarq) begin
                        state <= ST_ACT;
                        tmr   <= phases.act - TMR_W'(1);
                    end
                end
                ST_ACT: begin
                    if (tmr == '0) begin
                        state <= ST_REC;
                        tmr   <= phases.rec - TMR_W'(1);
                    end else begin
                        tmr <= tmr - TMR_W'(1);
                    end
                end
                ST_REC: begin
                    if (tmr != '0) begin
                        tmr <= tmr - TMR_W'(1);
                    end else if (last_word) begin
                        state <= ST_DONE;
                    end else if (dmarq) begin
                        state <= ST_ACT;
                        tmr   <= phases.act - TMR_W'(1);
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign word_end = (state == ST_ACT) && (tmr == '0);

endmodule

// File: rtl/mwdma_strobe_gen.sv
module mwdma_strobe_gen
    import mwdma_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int CNT_W   = 16,
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [DEV_W-1:0] cfg_dev,
    input  logic [1:0]       cfg_profile,
    input  logic             start,
    input  logic [DEV_W-1:0] start_dev,
    input  logic             start_dir,
    input  logic [CNT_W-1:0] start_words,
    input  logic             dmarq,
    output logic             dmack_n,
    output logic             dior_n,
    output logic             diow_n,
    output logic             busy,
    output logic             done
);

    state_e    state;
    logic      idle;
    logic      accept;
    logic      cfg_ok;
    logic      word_end;
    logic      last_word;
    profile_e  dev_prof;
    xfer_cfg_t cur_q;
    phase_t    phases;

    assign idle   = (state == ST_IDLE);
    assign accept = start && idle;
    assign cfg_ok = cfg_we && idle;

    mwdma_mode_regs #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_ok),
        .wr_dev  (cfg_dev),
        .wr_prof (profile_e'(cfg_profile)),
        .rd_dev  (start_dev),
        .rd_prof (dev_prof)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.prof <= PROF_A;
            cur_q.dir  <= 1'b0;
        end else if (accept) begin
            cur_q.prof <= dev_prof;
            cur_q.dir  <= start_dir;
        end
    end

    assign phases = profile_phases(cur_q.prof);

    mwdma_word_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (start_words),
        .dec      (word_end),
        .last     (last_word)
    );

    mwdma_phase_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .launch       (accept),
        .launch_empty (start_words == '0),
        .dmarq        (dmarq),
        .last_word    (last_word),
        .phases       (phases),
        .state        (state),
        .word_end     (word_end)
    );

    assign busy    = !idle;
    assign done    = (state == ST_DONE);
    assign dmack_n = !((state == ST_WAIT) || (state == ST_ACT) || (state == ST_REC));
    assign dior_n  = !((state == ST_ACT) && !cur_q.dir);
    assign diow_n  = !((state == ST_ACT) &&  cur_q.dir);

endmodule

// File: rtl/mwdma_strobe_chk.sv
module mwdma_strobe_chk (
    input logic clk,
    input logic rst,
    input logic dmarq,
    input logic dmack_n,
    input logic dior_n,
    input logic diow_n,
    input logic busy,
    input logic done
);

    logic any_lo;
    assign any_lo = !dior_n || !diow_n;

    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    a_r4_req_before_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(any_lo) |-> $past(dmarq));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r10_ack_with_strobe: assert property (@(posedge clk) disable iff (rst)
        any_lo |-> !dmack_n);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dior_n && diow_n && dmack_n));

endmodule

bind mwdma_strobe_gen mwdma_strobe_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .dmarq   (dmarq),
    .dmack_n (dmack_n),
    .dior_n  (dior_n),
    .diow_n  (diow_n),
    .busy    (busy),
    .done    (done)
);

// File: tb/test_mwdma_strobe_gen.sv
`timescale 1ns/1ps
module test_mwdma_strobe_gen;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [0:0]       cfg_dev = '0;
    logic [1:0]       cfg_profile = '0;
    logic             start = 1'b0;
    logic [0:0]       start_dev = '0;
    logic             start_dir = 1'b0;
    logic [CNT_W-1:0] start_words = '0;
    logic             dmarq = 1'b0;
    logic             dmack_n, dior_n, diow_n, busy, done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mwdma_strobe_gen #(.NUM_DEV(2), .CNT_W(CNT_W)) i_mwdma_strobe_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dev(cfg_dev),
        .cfg_profile(cfg_profile), .start(start), .start_dev(start_dev),
        .start_dir(start_dir), .start_words(start_words), .dmarq(dmarq),
        .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
        .busy(busy), .done(done)
    );

    function automatic int want_act(int p);
        case (p) 0: return 4; 1: return 3; 2: return 2; default: return 1; endcase
    endfunction
    function automatic int want_rec(int p);
        case (p) 0: return 5; 1: return 4; 2: return 2; default: return 2; endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_prof(input int dev, input int p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dev = 1'(dev); cfg_profile = 2'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one transfer with dmarq held high and measures every pulse.
    task automatic run_xfer(input int dev, input bit dir, input int words,
                            input int prof, input bit disturb, input string req);
        int runs = 0, cur_lo = 0, cur_hi = 0, bad_lo = 0, bad_hi = 0;
        int other = 0, noack = 0, cyc = 0;
        bit seen_done = 0, prev_lo = 0, lo;
        int ea = want_act(prof);
        int er = want_rec(prof);
        @(negedge clk);
        dmarq = 1'b1; start = 1'b1; start_dev = 1'(dev); start_dir = dir;
        start_words = CNT_W'(words);
        @(negedge clk);
        start = 1'b0; start_dir = ~dir;   // R8: input changes after acceptance
        while (!seen_done && cyc < 1000) begin
            lo = dir ? !diow_n : !dior_n;
            if (dir ? !dior_n : !diow_n) other++;
            if (lo && dmack_n) noack++;
            if (lo) begin
                if (!prev_lo) begin
                    if (runs > 0 && cur_hi != er) bad_hi++;
                    runs++;
                    cur_lo = 0;
                end
                cur_lo++;
            end else begin
                if (prev_lo) begin
                    if (cur_lo != ea) bad_lo++;
                    cur_hi = 0;
                end
                cur_hi++;
            end
            prev_lo = lo;
            seen_done = done;
            if (disturb && cyc == 2) begin
                // R6, R7: second start and profile write while busy
                start = 1'b1; start_dev = 1'(1 - dev); start_words = CNT_W'(7);
                cfg_we = 1'b1; cfg_dev = 1'(dev); cfg_profile = 2'd3;
            end
            if (disturb && cyc == 3) begin
                start = 1'b0; cfg_we = 1'b0;
            end
            cyc++;
            if (!seen_done) @(negedge clk);
        end
        check(seen_done, {req, " R5 done seen"}, int'(seen_done), 1);
        check(runs == words, {req, " R5 pulse count"}, runs, words);
        check(bad_lo == 0, {req, " R2 strobe-low length"}, bad_lo, 0);
        check(bad_hi == 0, {req, " R2 recovery length"}, bad_hi, 0);
        check(other == 0, {req, " R3 unused strobe high"}, other, 0);
        check(noack == 0, {req, " R10 ack during strobe"}, noack, 0);
        @(negedge clk);
        check(!done && !busy && dmack_n, {req, " R5 done one clock, idle after"},
              int'({done, busy, dmack_n}), 1);
    endtask

    task automatic t_reset;
        check(dior_n && diow_n && dmack_n, "R1 strobes/ack high",
              int'({dior_n, diow_n, dmack_n}), 7);
        check(!busy && !done, "R1 busy/done low", int'({busy, done}), 0);
        run_xfer(0, 1'b0, 2, 0, 1'b0, "R1 default profile dev0");
        run_xfer(1, 1'b1, 2, 0, 1'b0, "R1 default profile dev1");
    endtask

    task automatic t_profiles;
        for (int p = 1; p < 4; p++) begin
            write_prof(0, p);
            run_xfer(0, 1'(p & 1), 3, p, 1'b0, "R2 R3 profile sweep");
        end
    endtask

    task automatic t_per_device;
        write_prof(0, 3);
        write_prof(1, 1);
        run_xfer(1, 1'b0, 2, 1, 1'b0, "R9 dev1 keeps own code");
        run_xfer(0, 1'b1, 2, 3, 1'b0, "R9 dev0 keeps own code");
    endtask

    task automatic t_stall;
        int hi_bad = 0, lo_cnt = 0, cyc = 0;
        write_prof(0, 2);
        @(negedge clk);
        dmarq = 1'b0; start = 1'b1; start_dev = 1'b0; start_dir = 1'b0;
        start_words = CNT_W'(2);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!dior_n || !diow_n || dmack_n) hi_bad++;
            @(negedge clk);
        end
        check(hi_bad == 0, "R4 no strobe without dmarq, ack low", hi_bad, 0);
        dmarq = 1'b1;
        while (!done && cyc < 200) begin
            if (!dior_n) lo_cnt++;
            cyc++;
            @(negedge clk);
        end
        check(lo_cnt == 4, "R4 words after dmarq rises", lo_cnt, 4);
        @(negedge clk);
    endtask

    task automatic t_zero;
        int lo_seen = 0;
        @(negedge clk);
        start = 1'b1; start_dev = 1'b0; start_dir = 1'b1; start_words = '0;
        @(negedge clk);
        start = 1'b0;
        if (!dior_n || !diow_n) lo_seen++;
        check(done == 1'b1, "R5 zero count done next clock", int'(done), 1);
        @(negedge clk);
        check(!done && !busy && lo_seen == 0, "R5 zero count no strobe",
              int'({done, busy}) + lo_seen, 0);
    endtask

    task automatic t_disturb;
        write_prof(0, 2);
        run_xfer(0, 1'b0, 3, 2, 1'b1, "R6 R8 busy start/dir ignored");
        run_xfer(0, 1'b0, 2, 2, 1'b0, "R7 busy profile write dropped");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_profiles();
        t_per_device();
        t_stall();
        t_zero();
        t_disturb();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule